// File: doc/BRIEF.md
# DDR2 Write-Command Spacing Checker

This block watches the command stream that a DDR2 memory controller issues and judges every command against the spacing rules that a preceding WRITE burst imposes. It holds, for each rank, a record of the most recent WRITE: its bank, its burst length and its auto-precharge bit. It also keeps one auto-precharge timer per bank of each rank. Each record is cleared once its longest window has run out. All timing values are inputs, given in clock cycles: CAS latency, additive latency, write-to-read delay and write recovery.

The block has two outputs. The first is a combinational verdict on a candidate command that a scheduler is thinking of issuing, so that a scheduler can ask before it commits. The second is a registered violation flag with a reason code. It is raised one cycle after an illegal command has actually been issued. Both outputs come from the same rule logic, applied to the same stored state.

Top module: `wr_space_top`

## Requirements
- R1: After reset no write record exists, so every candidate is allowed and the violation flag is low with reason code 0.
- R2: A WRITE to a rank must come at least BL/2 clocks after the previous WRITE to that rank (2 for a 4-beat burst, 4 for an 8-beat burst). An earlier WRITE is flagged with reason code 1.
- R3: An 8-beat WRITE without auto precharge may be cut short by a WRITE to the same rank exactly 2 clocks after it. A WRITE 1 or 3 clocks after it is flagged with code 1, and so is a WRITE at 2 clocks when the first WRITE had auto precharge.
- R4: A READ to a rank needs at least WL + BL/2 + max(2, tWTR) clocks after that rank's last WRITE, where WL = CL + AL - 1. A READ sooner than that is flagged with reason code 2.
- R5: Commands to a rank other than the one written are never judged against that WRITE.
- R6: A PRECHARGE to the bank of the rank's last WRITE needs WL + BL/2 + tWR clocks. A sooner one is flagged with reason code 3. A PRECHARGE to any other bank is free.
- R7: An ACTIVATE to a bank that a WRITE with auto precharge is still closing needs WL + BL/2 + tWR clocks after that WRITE, using that WRITE's burst length. A sooner one is flagged with reason code 4. ACTIVATE to any other bank is free.
- R8: cand_ok is high in the same cycle exactly when the candidate command would raise no flag against the current state.
- R9: viol and viol_code are registered and reflect the command of the previous cycle. NOP (opcode 0) and the unused opcodes 5 to 7 are never flagged. The opcodes are 1 ACTIVATE, 2 READ, 3 WRITE and 4 PRECHARGE.
- R10: The auto-precharge timer of a bank survives later WRITEs to other banks of the same rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Opcode of the command issued this cycle |
| cmd_rank | input | RANK_W | Rank of the issued command |
| cmd_bank | input | BANK_W | Bank of the issued command |
| cmd_ap | input | 1 | Auto-precharge bit of the issued command |
| cmd_bl8 | input | 1 | Burst length of the issued WRITE: 1 for 8 beats, 0 for 4 beats |
| cand_op | input | 3 | Opcode of the candidate command |
| cand_rank | input | RANK_W | Rank of the candidate command |
| cand_bank | input | BANK_W | Bank of the candidate command |
| cfg_cl | input | CFG_W | CAS latency in clocks |
| cfg_al | input | CFG_W | Additive latency in clocks |
| cfg_twtr | input | CFG_W | Write-to-read delay in clocks |
| cfg_twr | input | CFG_W | Write recovery in clocks |
| cand_ok | output | 1 | Candidate is legal now |
| viol | output | 1 | Previous-cycle command broke a rule |
| viol_code | output | 3 | Rule that failed: 0 none, 1 write spacing, 2 write-to-read, 3 write recovery, 4 activate during auto precharge |

## Verification
Two cases are hard to reach: the single legal truncation slot of an 8-beat WRITE, and an ACTIVATE that meets a bank timer whose WRITE is no longer the rank's latest. The stimulus steers both on purpose. It issues WRITE, NOP, WRITE with the auto-precharge bit both clear and set. It then issues an auto-precharge WRITE, follows it with a plain WRITE to a second bank, and probes ACTIVATE to the first bank on both sides of its deadline. Randomized traffic over three timing sets, with bank numbers drawn from a narrow range so that collisions are frequent, covers the other edges against a behavioural model.

// File: rtl/wr_space_pkg.sv
package wr_space_pkg;

   typedef enum logic [2:0] {
      OP_NOP = 3'd0,
      OP_ACT = 3'd1,
      OP_RD  = 3'd2,
      OP_WR  = 3'd3,
      OP_PRE = 3'd4
   } op_e;

   typedef enum logic [2:0] {
      RSN_NONE = 3'd0,
      RSN_W2W  = 3'd1,
      RSN_W2R  = 3'd2,
      RSN_W2P  = 3'd3,
      RSN_ACT  = 3'd4
   } rsn_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // clocks from WRITE issue to the edge after the last data-in pair
   function automatic int burst_end(input int cl, input int al, input logic bl8);
      return cl + al - 1 + (bl8 ? 4 : 2);
   endfunction

endpackage

// File: rtl/wr_space_rank.sv
module wr_space_rank
   import wr_space_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int CNT_W  = 6,
   parameter int CFG_W  = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [BANK_W-1:0] wr_bank,
   input  logic              wr_ap,
   input  logic              wr_bl8,
   input  logic [CFG_W-1:0]  cfg_cl,
   input  logic [CFG_W-1:0]  cfg_al,
   input  logic [CFG_W-1:0]  cfg_twtr,
   input  logic [CFG_W-1:0]  cfg_twr,
   output logic              rec_valid,
   output logic [CNT_W-1:0]  rec_cnt,
   output logic [BANK_W-1:0] rec_bank,
   output logic              rec_ap,
   output logic              rec_bl8
);

   int lim;

   always_comb begin
      lim = burst_end(int'(cfg_cl), int'(cfg_al), rec_bl8)
          + imax(imax(2, int'(cfg_twtr)), int'(cfg_twr));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_valid <= 1'b0;
         rec_cnt   <= '0;
         rec_bank  <= '0;
         rec_ap    <= 1'b0;
         rec_bl8   <= 1'b0;
      end else if (wr_hit) begin
         rec_valid <= 1'b1;
         rec_cnt   <= CNT_W'(1);
         rec_bank  <= wr_bank;
         rec_ap    <= wr_ap;
         rec_bl8   <= wr_bl8;
      end else if (rec_valid) begin
         if (int'(rec_cnt) >= lim) rec_valid <= 1'b0;
         else                      rec_cnt   <= rec_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/wr_space_aptmr.sv
module wr_space_aptmr
   import wr_space_pkg::*;
#(
   parameter int CNT_W = 6,
   parameter int CFG_W = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set,
   input  logic             set_bl8,
   input  logic [CFG_W-1:0] cfg_cl,
   input  logic [CFG_W-1:0] cfg_al,
   input  logic [CFG_W-1:0] cfg_twr,
   output logic             ap_valid,
   output logic [CNT_W-1:0] ap_cnt,
   output logic             ap_bl8
);

   int lim;

   always_comb begin
      lim = burst_end(int'(cfg_cl), int'(cfg_al), ap_bl8) + int'(cfg_twr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ap_valid <= 1'b0;
         ap_cnt   <= '0;
         ap_bl8   <= 1'b0;
      end else if (set) begin
         ap_valid <= 1'b1;
         ap_cnt   <= CNT_W'(1);
         ap_bl8   <= set_bl8;
      end else if (ap_valid) begin
         if (int'(ap_cnt) >= lim) ap_valid <= 1'b0;
         else                     ap_cnt   <= ap_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/wr_space_eval.sv
module wr_space_eval
   import wr_space_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int CNT_W  = 6,
   parameter int CFG_W  = 4
)(
   input  logic [2:0]        op,
   input  logic [BANK_W-1:0] bank,
   input  logic              rv,
   input  logic [CNT_W-1:0]  rcnt,
   input  logic [BANK_W-1:0] rbank,
   input  logic              rap,
   input  logic              rbl8,
   input  logic              av,
   input  logic [CNT_W-1:0]  acnt,
   input  logic              abl8,
   input  logic [CFG_W-1:0]  cfg_cl,
   input  logic [CFG_W-1:0]  cfg_al,
   input  logic [CFG_W-1:0]  cfg_twtr,
   input  logic [CFG_W-1:0]  cfg_twr,
   output logic [2:0]        code
);

   int d_w, d_a, half, e_w, e_a, wtr;

   always_comb begin
      d_w  = int'(rcnt);
      d_a  = int'(acnt);
      half = rbl8 ? 4 : 2;
      e_w  = burst_end(int'(cfg_cl), int'(cfg_al), rbl8);
      e_a  = burst_end(int'(cfg_cl), int'(cfg_al), abl8);
      wtr  = imax(2, int'(cfg_twtr));
      code = RSN_NONE;
      case (op)
         OP_WR: begin
            if (rv && !(d_w >= half || (d_w == 2 && rbl8 && !rap)))
               code = RSN_W2W;
         end
         OP_RD: begin
            if (rv && d_w < e_w + wtr) code = RSN_W2R;
         end
         OP_PRE: begin
            if (rv && bank == rbank && d_w < e_w + int'(cfg_twr)) code = RSN_W2P;
         end
         OP_ACT: begin
            if (av && d_a < e_a + int'(cfg_twr)) code = RSN_ACT;
         end
         default: code = RSN_NONE;
      endcase
   end

endmodule

// File: rtl/wr_space_top.sv
module wr_space_top
   import wr_space_pkg::*;
#(
   parameter int RANKS  = 2,
   parameter int BANKS  = 8,
   parameter int CFG_W  = 4,
   parameter int CNT_W  = 6,
   localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
   localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd_op,
   input  logic [RANK_W-1:0] cmd_rank,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic              cmd_ap,
   input  logic              cmd_bl8,
   input  logic [2:0]        cand_op,
   input  logic [RANK_W-1:0] cand_rank,
   input  logic [BANK_W-1:0] cand_bank,
   input  logic [CFG_W-1:0]  cfg_cl,
   input  logic [CFG_W-1:0]  cfg_al,
   input  logic [CFG_W-1:0]  cfg_twtr,
   input  logic [CFG_W-1:0]  cfg_twr,
   output logic              cand_ok,
   output logic              viol,
   output logic [2:0]        viol_code
);

   localparam int NAP     = RANKS * BANKS;
   localparam int CFG_MAX = (1 << CFG_W) - 1;
   localparam int LIM_MAX = 3 * CFG_MAX + 3;

   if (RANKS < 1 || BANKS < 1) begin : g_bad_size
      $error("wr_space_top: RANKS and BANKS must be at least 1");
   end
   if (LIM_MAX > (1 << CNT_W) - 2) begin : g_bad_cnt
      $error("wr_space_top: CNT_W too narrow for the largest timing window");
   end

   logic              r_valid [RANKS];
   logic [CNT_W-1:0]  r_cnt   [RANKS];
   logic [BANK_W-1:0] r_bank  [RANKS];
   logic              r_ap    [RANKS];
   logic              r_bl8   [RANKS];
   logic              a_valid [NAP];
   logic [CNT_W-1:0]  a_cnt   [NAP];
   logic              a_bl8   [NAP];

   logic is_wr;
   assign is_wr = (cmd_op == OP_WR);

   for (genvar r = 0; r < RANKS; r++) begin : g_rank
      wr_space_rank #(.BANK_W(BANK_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_rank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_hit   (is_wr && int'(cmd_rank) == r),
         .wr_bank  (cmd_bank),
         .wr_ap    (cmd_ap),
         .wr_bl8   (cmd_bl8),
         .cfg_cl   (cfg_cl),
         .cfg_al   (cfg_al),
         .cfg_twtr (cfg_twtr),
         .cfg_twr  (cfg_twr),
         .rec_valid(r_valid[r]),
         .rec_cnt  (r_cnt[r]),
         .rec_bank (r_bank[r]),
         .rec_ap   (r_ap[r]),
         .rec_bl8  (r_bl8[r])
      );
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         wr_space_aptmr #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_ap (
            .clk     (clk),
            .rst_n   (rst_n),
            .set     (is_wr && cmd_ap && int'(cmd_rank) == r && int'(cmd_bank) == b),
            .set_bl8 (cmd_bl8),
            .cfg_cl  (cfg_cl),
            .cfg_al  (cfg_al),
            .cfg_twr (cfg_twr),
            .ap_valid(a_valid[r*BANKS+b]),
            .ap_cnt  (a_cnt[r*BANKS+b]),
            .ap_bl8  (a_bl8[r*BANKS+b])
         );
      end
   end

   // record selection for the issued command and for the candidate
   logic              c_rv, q_rv, c_rap, q_rap, c_rbl8, q_rbl8;
   logic [CNT_W-1:0]  c_rcnt, q_rcnt, c_acnt, q_acnt;
   logic [BANK_W-1:0] c_rbank, q_rbank;
   logic              c_av, q_av, c_abl8, q_abl8;

   always_comb begin
      c_rv = 1'b0; c_rcnt = '0; c_rbank = '0; c_rap = 1'b0; c_rbl8 = 1'b0;
      q_rv = 1'b0; q_rcnt = '0; q_rbank = '0; q_rap = 1'b0; q_rbl8 = 1'b0;
      c_av = 1'b0; c_acnt = '0; c_abl8 = 1'b0;
      q_av = 1'b0; q_acnt = '0; q_abl8 = 1'b0;
      for (int i = 0; i < RANKS; i++) begin
         if (int'(cmd_rank) == i) begin
            c_rv = r_valid[i]; c_rcnt = r_cnt[i]; c_rbank = r_bank[i];
            c_rap = r_ap[i]; c_rbl8 = r_bl8[i];
         end
         if (int'(cand_rank) == i) begin
            q_rv = r_valid[i]; q_rcnt = r_cnt[i]; q_rbank = r_bank[i];
            q_rap = r_ap[i]; q_rbl8 = r_bl8[i];
         end
      end
      for (int k = 0; k < NAP; k++) begin
         if (int'(cmd_rank) * BANKS + int'(cmd_bank) == k && int'(cmd_bank) < BANKS) begin
            c_av = a_valid[k]; c_acnt = a_cnt[k]; c_abl8 = a_bl8[k];
         end
         if (int'(cand_rank) * BANKS + int'(cand_bank) == k && int'(cand_bank) < BANKS) begin
            q_av = a_valid[k]; q_acnt = a_cnt[k]; q_abl8 = a_bl8[k];
         end
      end
   end

   logic [2:0] cmd_code, cand_code;

   wr_space_eval #(.BANK_W(BANK_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_eval_cmd (
      .op(cmd_op), .bank(cmd_bank),
      .rv(c_rv), .rcnt(c_rcnt), .rbank(c_rbank), .rap(c_rap), .rbl8(c_rbl8),
      .av(c_av), .acnt(c_acnt), .abl8(c_abl8),
      .cfg_cl(cfg_cl), .cfg_al(cfg_al), .cfg_twtr(cfg_twtr), .cfg_twr(cfg_twr),
      .code(cmd_code)
   );

   wr_space_eval #(.BANK_W(BANK_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_eval_cand (
      .op(cand_op), .bank(cand_bank),
      .rv(q_rv), .rcnt(q_rcnt), .rbank(q_rbank), .rap(q_rap), .rbl8(q_rbl8),
      .av(q_av), .acnt(q_acnt), .abl8(q_abl8),
      .cfg_cl(cfg_cl), .cfg_al(cfg_al), .cfg_twtr(cfg_twtr), .cfg_twr(cfg_twr),
      .code(cand_code)
   );

   assign cand_ok = (cand_code == RSN_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol      <= 1'b0;
         viol_code <= RSN_NONE;
      end else begin
         viol      <= (cmd_code != RSN_NONE);
         viol_code <= cmd_code;
      end
   end

endmodule

// File: rtl/wr_space_chk.sv
module wr_space_chk
   import wr_space_pkg::*;
#(
   parameter int RANK_W = 1,
   parameter int BANK_W = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        cmd_op,
   input logic [RANK_W-1:0] cmd_rank,
   input logic [BANK_W-1:0] cmd_bank,
   input logic              cmd_ap,
   input logic              cmd_bl8,
   input logic [2:0]        cand_op,
   input logic [RANK_W-1:0] cand_rank,
   input logic [BANK_W-1:0] cand_bank,
   input logic              cand_ok,
   input logic              viol,
   input logic [2:0]        viol_code
);

   // R2: a WRITE right after a 4-beat WRITE to the same rank is flagged
   a_r2_bl4_no_interrupt: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == OP_WR && !cmd_bl8) ##1 (cmd_op == OP_WR && cmd_rank == $past(cmd_rank))
      |=> (viol && viol_code == RSN_W2W));

   // R3: truncation of an 8-beat plain WRITE two clocks later is legal
   a_r3_trunc_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == OP_WR && cmd_bl8 && !cmd_ap) ##1 (cmd_op == OP_NOP)
      ##1 (cmd_op == OP_WR && cmd_rank == $past(cmd_rank, 2))
      |=> !viol);

   // R4: a READ one clock after a WRITE to the same rank is always too early
   a_r4_read_too_soon: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == OP_WR) ##1 (cmd_op == OP_RD && cmd_rank == $past(cmd_rank))
      |=> (viol && viol_code == RSN_W2R));

   // R8: the candidate verdict agrees with the flag raised for the same command
   a_r8_cand_agrees: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_op == cmd_op && cand_rank == cmd_rank && cand_bank == cmd_bank)
      |=> (viol == !$past(cand_ok)));

   // R9: a NOP never raises the flag
   a_r9_nop_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == OP_NOP) |=> (!viol && viol_code == RSN_NONE));

endmodule

bind wr_space_top wr_space_chk #(.RANK_W(RANK_W), .BANK_W(BANK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_rank(cmd_rank),
   .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cmd_bl8(cmd_bl8),
   .cand_op(cand_op), .cand_rank(cand_rank), .cand_bank(cand_bank),
   .cand_ok(cand_ok), .viol(viol), .viol_code(viol_code)
);

// File: tb/wr_space_top_tb.sv
module wr_space_top_tb;

   localparam int RANKS = 2;
   localparam int BANKS = 8;
   localparam int RW = 1;
   localparam int BW = 3;

   localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] cmd_op = NOP, cand_op = NOP;
   logic [RW-1:0] cmd_rank = '0, cand_rank = '0;
   logic [BW-1:0] cmd_bank = '0, cand_bank = '0;
   logic cmd_ap = 1'b0, cmd_bl8 = 1'b0;
   logic [3:0] cfg_cl = 4'd4, cfg_al = 4'd0, cfg_twtr = 4'd3, cfg_twr = 4'd4;
   logic cand_ok, viol;
   logic [2:0] viol_code;

   always #5 clk = ~clk;

   wr_space_top #(.RANKS(RANKS), .BANKS(BANKS)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_op(cmd_op), .cmd_rank(cmd_rank), .cmd_bank(cmd_bank),
      .cmd_ap(cmd_ap), .cmd_bl8(cmd_bl8),
      .cand_op(cand_op), .cand_rank(cand_rank), .cand_bank(cand_bank),
      .cfg_cl(cfg_cl), .cfg_al(cfg_al), .cfg_twtr(cfg_twtr), .cfg_twr(cfg_twr),
      .cand_ok(cand_ok), .viol(viol), .viol_code(viol_code)
   );

   int vectors = 0, fails = 0;
   int cyc = 0;
   int wt[RANKS], wbank[RANKS];
   bit wap[RANKS], wbl8[RANKS];
   int apt[RANKS][BANKS];
   bit apbl8[RANKS][BANKS];
   int prev_code = 0;
   string prev_tag = "R1";
   bit done = 0;

   function automatic int mx(int a, int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int bend(bit bl8);
      return int'(cfg_cl) + int'(cfg_al) - 1 + (bl8 ? 4 : 2);
   endfunction

   // behavioural rule model from the requirements
   function automatic int model(logic [2:0] op, int r, int b);
      int d = cyc - wt[r];
      int da = cyc - apt[r][b];
      case (op)
         WR:  if (!(d >= (wbl8[r] ? 4 : 2) || (d == 2 && wbl8[r] && !wap[r]))) return 1;
         RD:  if (d < bend(wbl8[r]) + mx(2, int'(cfg_twtr))) return 2;
         PRE: if (b == wbank[r] && d < bend(wbl8[r]) + int'(cfg_twr)) return 3;
         ACT: if (da < bend(apbl8[r][b]) + int'(cfg_twr)) return 4;
         default: return 0;
      endcase
      return 0;
   endfunction

   function automatic string tag_of(logic [2:0] op);
      case (op)
         WR: return "R2";
         RD: return "R4";
         PRE: return "R6";
         ACT: return "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic check(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic step(logic [2:0] op, int r, int b, bit ap, bit bl8,
                       logic [2:0] cop, int cr, int cb, string tag);
      @(negedge clk);
      cmd_op = op; cmd_rank = r[RW-1:0]; cmd_bank = b[BW-1:0];
      cmd_ap = ap; cmd_bl8 = bl8;
      cand_op = cop; cand_rank = cr[RW-1:0]; cand_bank = cb[BW-1:0];
      #1;
      check("R8", int'(cand_ok), (model(cop, cr, cb) == 0) ? 1 : 0);
      check(prev_tag, int'(viol), (prev_code != 0) ? 1 : 0);
      check(prev_tag, int'(viol_code), prev_code);
      prev_code = model(op, r, b);
      prev_tag = tag;
      if (op == WR) begin
         wt[r] = cyc; wbank[r] = b; wap[r] = ap; wbl8[r] = bl8;
         if (ap) begin apt[r][b] = cyc; apbl8[r][b] = bl8; end
      end
      cyc++;
   endtask

   // same command offered as candidate
   task automatic cmd(logic [2:0] op, int r, int b, bit ap, bit bl8, string tag);
      step(op, r, b, ap, bl8, op, r, b, tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cmd(NOP, 0, 0, 0, 0, "R9");
   endtask

   initial begin
      for (int r = 0; r < RANKS; r++) begin
         wt[r] = -1000; wbank[r] = 0; wap[r] = 0; wbl8[r] = 0;
         for (int b = 0; b < BANKS; b++) begin apt[r][b] = -1000; apbl8[r][b] = 0; end
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      #1;
      check("R1", int'(viol), 0);
      check("R1", int'(viol_code), 0);
      step(NOP, 0, 0, 0, 0, RD, 0, 0, "R1");
      step(NOP, 0, 0, 0, 0, PRE, 1, 3, "R1");
      step(NOP, 0, 0, 0, 0, ACT, 1, 5, "R1");

      // cfg CL4 AL0 tWTR3 tWR4: 4-beat end 5, 8-beat end 7
      // R2: 4-beat WRITE followed too soon, then at BL/2
      cmd(WR, 0, 0, 0, 0, "R2");
      cmd(WR, 0, 1, 0, 0, "R2");
      cmd(NOP, 0, 0, 0, 0, "R9");
      cmd(WR, 0, 1, 0, 0, "R2");
      idle(40);
      // R3: truncation slot of an 8-beat write
      cmd(WR, 0, 0, 0, 1, "R3");
      cmd(NOP, 0, 0, 0, 0, "R9");
      cmd(WR, 0, 0, 0, 1, "R3");
      idle(40);
      cmd(WR, 0, 0, 1, 1, "R3");
      cmd(NOP, 0, 0, 0, 0, "R9");
      cmd(WR, 0, 2, 0, 1, "R3");
      idle(40);
      cmd(WR, 1, 0, 0, 1, "R3");
      idle(2);
      cmd(WR, 1, 0, 0, 1, "R3");
      idle(40);
      // R4: READ window edges, 4-beat: 5 + 3 = 8 clocks
      cmd(WR, 0, 3, 0, 0, "R4");
      idle(6);
      cmd(RD, 0, 3, 0, 0, "R4");
      cmd(RD, 0, 3, 0, 0, "R4");
      idle(40);
      // R5: other rank ignores the write
      cmd(WR, 0, 4, 1, 1, "R5");
      cmd(RD, 1, 4, 0, 0, "R5");
      cmd(PRE, 1, 4, 0, 0, "R5");
      cmd(WR, 1, 4, 0, 0, "R5");
      cmd(ACT, 1, 4, 0, 0, "R5");
      idle(40);
      // R6: PRECHARGE same bank edge 8-beat: 7 + 4 = 11; other bank free
      cmd(WR, 1, 6, 0, 1, "R6");
      cmd(PRE, 1, 2, 0, 0, "R6");
      idle(8);
      cmd(PRE, 1, 6, 0, 0, "R6");
      cmd(PRE, 1, 6, 0, 0, "R6");
      idle(40);
      // R7 and R10: AP timer on bank 5 survives a write to bank 1
      cmd(WR, 0, 5, 1, 0, "R7");
      idle(3);
      cmd(WR, 0, 1, 0, 0, "R10");
      cmd(ACT, 0, 5, 0, 0, "R10");
      cmd(ACT, 0, 1, 0, 0, "R7");
      idle(2);
      cmd(ACT, 0, 5, 0, 0, "R7");
      cmd(ACT, 0, 5, 0, 0, "R7");
      idle(40);
      // R9: unused opcodes
      cmd(WR, 1, 0, 0, 0, "R9");
      cmd(3'd5, 1, 0, 0, 0, "R9");
      cmd(3'd7, 1, 0, 0, 0, "R9");
      idle(40);

      // randomized traffic over three timing sets
      for (int ph = 0; ph < 3; ph++) begin
         case (ph)
            0: begin cfg_cl = 4'd3; cfg_al = 4'd0; cfg_twtr = 4'd2;  cfg_twr = 4'd3;  end
            1: begin cfg_cl = 4'd5; cfg_al = 4'd2; cfg_twtr = 4'd6;  cfg_twr = 4'd5;  end
            default: begin cfg_cl = 4'd7; cfg_al = 4'd6; cfg_twtr = 4'd15; cfg_twr = 4'd15; end
         endcase
         for (int i = 0; i < 1500; i++) begin
            logic [2:0] op;
            logic [2:0] cop;
            op = ($urandom_range(0, 3) == 0) ? NOP : 3'($urandom_range(0, 7));
            cop = 3'($urandom_range(0, 7));
            step(op, $urandom_range(0, 1), $urandom_range(0, 2),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 cop, $urandom_range(0, 1), $urandom_range(0, 2), tag_of(op));
         end
         idle(60);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule